// File: doc/BRIEF.md
# Programmable Glue Logic Lookup Array

This block holds a row of small configurable lookup cells that turn groups of external input lines into custom combinational glue. Cell c owns the four inputs `lutIn[4c+3:4c]` and drives the single output `lutOut[c]`. Every input passes through its own enable gate, and the gated nibble selects one bit from a 16-bit truth word held for that cell. The number of cells is a parameter, with a default of two.

Software sets up each cell through a plain synchronous register port. Each cell has a control word, which holds the per-input enables and a filter select, and a truth word. When the filter is selected, the cell output runs through a glitch suppressor in a second clock domain. That domain brings the inputs in through two-flop synchronizers and lets a new level through only after it has held for three consecutive filter-clock cycles. The configuration registers are treated as quasi-static with respect to that domain.

Top module: `glue_lut_array`

## Requirements
- R1: While `busRstN` is low, every register reads zero. Once reset is released, all outputs are zero until a register is written.
- R2: When a cell's four enables are set and its filter is off, `lutOut[c]` equals bit `{in3,in2,in1,in0}` of the cell's truth word. Input `lutIn[4c]` is the least significant index bit.
- R3: An input whose enable bit is clear counts as 0 in the index, whatever level is on the pin.
- R4: When a cell has no enabled inputs and its filter is off, its output equals bit 0 of its truth word for every input pattern.
- R5: Word address 2c is cell c's control word, with filter select at bit 31 and input enables at bits 3:0 (bit k gates input k). Word address 2c+1 is the truth word, bits 15:0. Every other bit reads zero, and both words reset to zero.
- R6: With the filter off, the output follows input and configuration changes combinationally, with no clock edge needed.
- R7: With the filter on, an input change applied between filter-clock edges reaches `lutOut` at the fifth rising `gclk` edge after it: two synchronizer stages plus three stable cycles. A change that lasts only two filter-clock cycles never reaches the output.
- R8: A write to one cell's registers leaves every other cell's registers and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register port clock |
| busRstN | input | 1 | Active-low reset of the register file |
| gclk | input | 1 | Filter-domain clock |
| gclkRstN | input | 1 | Active-low reset of the filter domain |
| regWrEn | input | 1 | Write strobe, sampled on busClk |
| regAddr | input | $clog2(NUM_CELLS)+1 | Word address (2c control, 2c+1 truth) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| lutIn | input | 4*NUM_CELLS | Cell inputs, four per cell |
| lutOut | output | NUM_CELLS | Cell outputs |

## Verification
The hardest case to reach from the ports is a filtered glitch that comes close to the three-cycle threshold but misses it. The filter counter has to climb to its last step before falling back, and the committed level must stay put. The bench places input edges on `gclk` falling edges, so every synchronizer stage takes the new level at a known rising edge. It then holds a low pulse for exactly two filter cycles and watches the output for many cycles afterward. It also counts edges on a real change, checking the fourth edge and the fifth edge separately, so a shortened or lengthened pipeline shows up.

// File: rtl/glue_lut_pkg.sv
package glue_lut_pkg;
  localparam int CELL_INPUTS = 4;
  localparam int TRUTH_W     = 1 << CELL_INPUTS;
  localparam int FILT_CYCLES = 3;
  localparam int FILT_CNT_W  = $clog2(FILT_CYCLES);

  // Per-cell configuration handed from the register file to the datapath.
  typedef struct packed {
    logic                   filtEn;
    logic [CELL_INPUTS-1:0] inEn;
    logic [TRUTH_W-1:0]     truth;
  } cellCfg_t;
endpackage

// File: rtl/glue_lut_regs.sv
module glue_lut_regs
  import glue_lut_pkg::*;
#(
  parameter int NUM_CELLS = 2,
  parameter int ADDR_W    = $clog2(NUM_CELLS) + 1
) (
  input  logic                  busClk,
  input  logic                  busRstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output cellCfg_t [NUM_CELLS-1:0] cellCfg
);
  logic isTruth;
  logic [ADDR_W-1:0] cellSel;
  logic wrUnused;

  assign isTruth  = regAddr[0];
  assign cellSel  = regAddr >> 1;
  assign wrUnused = ^regWrData[30:16];

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic hit;
    assign hit = regWrEn && (cellSel == ADDR_W'(c));

    always_ff @(posedge busClk or negedge busRstN) begin
      if (!busRstN) begin
        cellCfg[c] <= '0;
      end else if (hit) begin
        if (isTruth) begin
          cellCfg[c].truth <= regWrData[TRUTH_W-1:0];
        end else begin
          cellCfg[c].filtEn <= regWrData[31];
          cellCfg[c].inEn   <= regWrData[CELL_INPUTS-1:0];
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (cellSel == ADDR_W'(c)) begin
        if (isTruth) begin
          regRdData[TRUTH_W-1:0] = cellCfg[c].truth;
        end else begin
          regRdData[31]                = cellCfg[c].filtEn;
          regRdData[CELL_INPUTS-1:0]   = cellCfg[c].inEn;
        end
      end
    end
  end
endmodule

// File: rtl/glue_lut_datapath.sv
module glue_lut_datapath
  import glue_lut_pkg::*;
#(
  parameter int NUM_CELLS = 2,
  parameter int IN_W      = NUM_CELLS * CELL_INPUTS
) (
  input  logic                     gclk,
  input  logic                     gclkRstN,
  input  logic [IN_W-1:0]          lutIn,
  input  cellCfg_t [NUM_CELLS-1:0] cellCfg,
  output logic [NUM_CELLS-1:0]     lutOut,
  output logic [NUM_CELLS-1:0]     cellRaw,
  output logic [NUM_CELLS-1:0]     cellFilt
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic [CELL_INPUTS-1:0] pinGrp;
    logic [CELL_INPUTS-1:0] directIdx;
    logic                   directOut;
    logic [CELL_INPUTS-1:0] syncA;
    logic [CELL_INPUTS-1:0] syncB;
    logic [CELL_INPUTS-1:0] syncIdx;
    logic [FILT_CNT_W-1:0]  stableCnt;
    logic                   filtQ;

    assign pinGrp    = lutIn[c*CELL_INPUTS +: CELL_INPUTS];
    assign directIdx = pinGrp & cellCfg[c].inEn;
    assign directOut = cellCfg[c].truth[directIdx];

    // Two-flop synchronizer into the filter clock domain.
    always_ff @(posedge gclk or negedge gclkRstN) begin
      if (!gclkRstN) begin
        syncA <= '0;
        syncB <= '0;
      end else begin
        syncA <= pinGrp;
        syncB <= syncA;
      end
    end

    assign syncIdx    = syncB & cellCfg[c].inEn;
    assign cellRaw[c] = cellCfg[c].truth[syncIdx];

    // Commit a new level only after FILT_CYCLES consecutive differing samples.
    always_ff @(posedge gclk or negedge gclkRstN) begin
      if (!gclkRstN) begin
        stableCnt <= '0;
        filtQ     <= 1'b0;
      end else if (cellRaw[c] == filtQ) begin
        stableCnt <= '0;
      end else if (stableCnt == FILT_CNT_W'(FILT_CYCLES - 1)) begin
        stableCnt <= '0;
        filtQ     <= cellRaw[c];
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end

    assign cellFilt[c] = filtQ;
    assign lutOut[c]   = cellCfg[c].filtEn ? filtQ : directOut;
  end
endmodule

// File: rtl/glue_lut_array.sv
module glue_lut_array
  import glue_lut_pkg::*;
#(
  parameter int NUM_CELLS = 2,
  parameter int ADDR_W    = $clog2(NUM_CELLS) + 1,
  parameter int IN_W      = NUM_CELLS * CELL_INPUTS
) (
  input  logic                 busClk,
  input  logic                 busRstN,
  input  logic                 gclk,
  input  logic                 gclkRstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [IN_W-1:0]      lutIn,
  output logic [NUM_CELLS-1:0] lutOut
);
  cellCfg_t [NUM_CELLS-1:0] cellCfg;
  logic [NUM_CELLS-1:0]     cellRaw;
  logic [NUM_CELLS-1:0]     cellFilt;

  glue_lut_regs #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_regs (
    .busClk(busClk), .busRstN(busRstN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cellCfg(cellCfg)
  );

  glue_lut_datapath #(.NUM_CELLS(NUM_CELLS), .IN_W(IN_W)) u_dp (
    .gclk(gclk), .gclkRstN(gclkRstN), .lutIn(lutIn), .cellCfg(cellCfg),
    .lutOut(lutOut), .cellRaw(cellRaw), .cellFilt(cellFilt)
  );
endmodule

// File: rtl/glue_lut_array_chk.sv
module glue_lut_array_chk
  import glue_lut_pkg::*;
#(
  parameter int NUM_CELLS = 2,
  parameter int ADDR_W    = $clog2(NUM_CELLS) + 1,
  parameter int IN_W      = NUM_CELLS * CELL_INPUTS
) (
  input logic                     busClk,
  input logic                     busRstN,
  input logic                     gclk,
  input logic                     gclkRstN,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [31:0]              regRdData,
  input logic [IN_W-1:0]          lutIn,
  input logic [NUM_CELLS-1:0]     lutOut,
  input cellCfg_t [NUM_CELLS-1:0] cellCfg,
  input logic [NUM_CELLS-1:0]     cellRaw,
  input logic [NUM_CELLS-1:0]     cellFilt
);
  // R1: register reads are zero while reset is held.
  always @(negedge busClk) begin
    if (!busRstN) begin
      assert_reset_zero_R1: assert (regRdData == 32'd0);
    end
  end

  // R5: unused bits of both word kinds read zero.
  assert_ctrl_reserved_R5: assert property (@(posedge busClk) disable iff (!busRstN)
    !regAddr[0] |-> regRdData[30:CELL_INPUTS] == '0);
  assert_truth_reserved_R5: assert property (@(posedge busClk) disable iff (!busRstN)
    regAddr[0] |-> regRdData[31:TRUTH_W] == '0);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    // R2: unfiltered output matches the selected truth bit.
    assert_lookup_R2: assert property (@(posedge busClk) disable iff (!busRstN)
      !cellCfg[c].filtEn |->
        lutOut[c] == cellCfg[c].truth[lutIn[c*CELL_INPUTS +: CELL_INPUTS] & cellCfg[c].inEn]);
    // R3: a disabled input 0 never sets the low index bit.
    assert_gate_R3: assert property (@(posedge busClk) disable iff (!busRstN)
      (!cellCfg[c].filtEn && !cellCfg[c].inEn[0]) |->
        lutOut[c] == cellCfg[c].truth[{lutIn[c*CELL_INPUTS+1 +: 3] & cellCfg[c].inEn[3:1], 1'b0}]);
    // R4: no enabled inputs gives bit 0 of the truth word.
    assert_none_enabled_R4: assert property (@(posedge busClk) disable iff (!busRstN)
      (!cellCfg[c].filtEn && cellCfg[c].inEn == '0) |-> lutOut[c] == cellCfg[c].truth[0]);
    // R7: a committed filter level was seen for three straight samples.
    assert_filter_stable_R7: assert property (@(posedge gclk) disable iff (!gclkRstN)
      (cellFilt[c] != $past(cellFilt[c])) |->
        ($past(cellRaw[c], 1) == cellFilt[c] && $past(cellRaw[c], 2) == cellFilt[c] &&
         $past(cellRaw[c], 3) == cellFilt[c]));
  end
endmodule

bind glue_lut_array glue_lut_array_chk #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W), .IN_W(IN_W)) u_chk (
  .busClk(busClk), .busRstN(busRstN), .gclk(gclk), .gclkRstN(gclkRstN),
  .regAddr(regAddr), .regRdData(regRdData), .lutIn(lutIn), .lutOut(lutOut),
  .cellCfg(cellCfg), .cellRaw(cellRaw), .cellFilt(cellFilt)
);

// File: tb/glue_lut_array_tb.sv
`timescale 1ns/1ps
module glue_lut_array_tb;
  localparam int N = 2;
  localparam int AW = $clog2(N) + 1;

  logic busClk = 1'b0;
  logic gclk = 1'b0;
  logic busRstN = 1'b0;
  logic gclkRstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4*N-1:0] lutIn = '0;
  logic [N-1:0] lutOut;
  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 busClk = ~busClk;
  always #6 gclk = ~gclk;

  glue_lut_array #(.NUM_CELLS(N)) u_dut (
    .busClk(busClk), .busRstN(busRstN), .gclk(gclk), .gclkRstN(gclkRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .lutIn(lutIn), .lutOut(lutOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge busClk);
    regAddr = AW'(addr); regWrData = data; regWrEn = 1'b1;
    @(posedge busClk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge busClk);
    regAddr = AW'(addr);
    #1 data = regRdData;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  task automatic test_reset;
    logic [31:0] d;
    for (int a = 0; a < 2*N; a++) begin
      regAddr = AW'(a); #1;
      chk("R1 reg during reset", regRdData, 32'd0);
    end
    @(negedge busClk); busRstN = 1'b1; gclkRstN = 1'b1;
    rd(0, d);
    chk("R1 output after reset", 32'(lutOut), 32'd0);
  endtask

  task automatic test_regmap;
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R5 ctrl readback", d, 32'h8000_000F);
    wr(3, 32'hABCD_1234);
    rd(3, d); chk("R5 truth readback", d, 32'h0000_1234);
    rd(0, d); chk("R8 cell0 ctrl untouched", d, 32'd0);
    rd(1, d); chk("R8 cell0 truth untouched", d, 32'd0);
    wr(2, 32'd0); wr(3, 32'd0);
    rd(2, d); chk("R5 ctrl cleared", d, 32'd0);
  endtask

  task automatic test_lookup;
    logic [15:0] t0 = 16'h8E35;
    logic [15:0] t1 = 16'h51CA;
    wr(0, 32'hF); wr(1, 32'(t0));
    wr(2, 32'hF); wr(3, 32'(t1));
    for (int v = 0; v < 16; v++) begin
      @(negedge busClk);
      lutIn = {4'(15 - v), 4'(v)};
      #1;
      chk("R2 cell0 lookup", 32'(lutOut[0]), 32'(t0[v]));
      chk("R2 cell1 lookup", 32'(lutOut[1]), 32'(t1[15 - v]));
    end
  endtask

  task automatic test_gating;
    logic [15:0] t = 16'h6B1D;
    wr(0, 32'h5); wr(1, 32'(t));
    for (int v = 0; v < 16; v++) begin
      @(negedge busClk);
      lutIn[3:0] = 4'(v);
      #1 chk("R3 disabled inputs read as zero", 32'(lutOut[0]), 32'(t[v & 5]));
    end
  endtask

  task automatic test_none;
    wr(0, 32'h0); wr(1, 32'h0001);
    for (int v = 0; v < 16; v += 5) begin
      @(negedge busClk); lutIn[3:0] = 4'(v);
      #1 chk("R4 none enabled, lsb one", 32'(lutOut[0]), 32'd1);
    end
    wr(1, 32'hFFFE);
    #1 chk("R4 none enabled, lsb zero", 32'(lutOut[0]), 32'd0);
  endtask

  task automatic test_independent;
    wr(2, 32'h0); wr(3, 32'h0000);
    wr(0, 32'h0); wr(1, 32'hFFFF);
    #1 chk("R8 cell0 set", 32'(lutOut[0]), 32'd1);
    chk("R8 cell1 unaffected", 32'(lutOut[1]), 32'd0);
  endtask

  task automatic test_direct;
    wr(0, 32'h1); wr(1, 32'h0002);
    @(negedge busClk); lutIn[3:0] = 4'h0;
    #1 chk("R6 direct low", 32'(lutOut[0]), 32'd0);
    #1 lutIn[0] = 1'b1;
    #1 chk("R6 direct follows without clock", 32'(lutOut[0]), 32'd1);
  endtask

  task automatic test_filter;
    @(negedge busClk); lutIn[3:0] = 4'h0;
    wr(1, 32'h0002); wr(0, 32'h8000_0001);
    repeat (6) @(posedge gclk);
    @(negedge gclk); chk("R7 filtered idle low", 32'(lutOut[0]), 32'd0);
    lutIn[0] = 1'b1;
    repeat (4) @(posedge gclk);
    @(negedge gclk); chk("R7 not yet at edge four", 32'(lutOut[0]), 32'd0);
    @(posedge gclk);
    @(negedge gclk); chk("R7 rise at edge five", 32'(lutOut[0]), 32'd1);
    // Two-cycle low glitch must be swallowed.
    lutIn[0] = 1'b0;
    repeat (2) @(posedge gclk);
    @(negedge gclk); lutIn[0] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge gclk);
      chk("R7 short glitch suppressed", 32'(lutOut[0]), 32'd1);
    end
    lutIn[0] = 1'b0;
    repeat (4) @(posedge gclk);
    @(negedge gclk); chk("R7 fall not yet at edge four", 32'(lutOut[0]), 32'd1);
    @(posedge gclk);
    @(negedge gclk); chk("R7 fall at edge five", 32'(lutOut[0]), 32'd0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    test_reset();
    test_regmap();
    test_lookup();
    test_gating();
    test_none();
    test_independent();
    test_direct();
    test_filter();
    done = 1'b1;
    report();
  end
endmodule